// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Masked Output Writes

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped into four banks whose widths are parameters (32, 22, 32 and 32 by default, 118 pins in all). Software reaches it through a plain 32-bit register bus. Each bank has three read/write-visible resources: a direction register, an output-enable register and a read-only register of sampled pin levels. A pin drives its output value only when both its direction bit and its enable bit are set. Every other pin is left undriven.

Output values are never written as a full word. Each bank has two write-only half-word ports. One covers pins 0–15 and the other covers pins 16–31. Every write to these ports carries a 16-bit protect mask in its upper half and 16 data bits in its lower half. Software can therefore flip a single pin atomically, with no read-modify-write of the whole bank.

The bus is a control path and has no back-pressure. A write takes effect on the clock edge where it is presented. A read returns its data on the next cycle, together with a one-cycle valid strobe. Two pins in bank 0 (bits 7 and 8 by default, set by a parameter mask) are permanently outputs.

Top module: `mbgpio_top`

## Requirements
- R1: After reset every output value bit and every output-enable bit is 0, so no pin is driven. Every direction bit is 0 except the forced bank 0 bits, which read as 1 (bank 0 direction reads 0x00000180).
- R2: A write to the low masked port of bank b (byte offset 0x000 + 8*b) sets output bit i (0–15) to write-data bit i wherever write-data bit 16+i is 0.
- R3: A write to the high masked port of bank b (offset 0x004 + 8*b) sets output bit 16+i to write-data bit i wherever write-data bit 16+i is 0. The lower 16 output bits do not change.
- R4: Output bits whose protect-mask bit (write-data bit 16+i) is 1 keep their previous value.
- R5: The direction register of bank b (offset 0x208 - 4 + 0x40*b, i.e. 0x204 + 0x40*b) reads back what was written. Bit = 1 selects output.
- R6: The output-enable register of bank b (offset 0x208 + 0x40*b) reads back what was written. pin_oe of a pin is 1 exactly when its direction bit and its enable bit are both 1.
- R7: In bank 0, the direction bits named by the forced mask (bits 7 and 8) stay 1. A write that tries to clear them is ignored for those bits.
- R8: The level register of bank b (offset 0x060 + 4*b) returns each undriven pin's pin_in level through a two-flop synchronizer. A level held for two clock edges is returned by a read issued on the following edge.
- R9: For a driven pin, the level register returns the driven output value, with the same synchronizer delay.
- R10: Register bits at or above a bank's pin count read as 0 and ignore writes. For example, bank 1 direction written with 0xFFFFFFFF reads 0x003FFFFF.
- R11: Reads of the write-only masked ports or of unmapped offsets return 0. Writes to the level registers or to unmapped offsets change no pin output, enable or register.
- R12: bus_rvalid is 1 in exactly the cycle after a cycle with bus_rd high, and bus_rdata holds the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 10 | Byte address; must match an offset exactly |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pin_in | input | 118 | Sampled pin levels, bank 0 in the low bits |
| pin_out | output | 118 | Output value of each pin |
| pin_oe | output | 118 | Drive enable of each pin |

## Verification
The bench builds the block with its default parameters: bank widths 32, 22, 32 and 32 and a forced-output mask of 0x180 on bank 0. The 22-pin bank puts a partly populated high half-word port and unimplemented register bits within reach. The full-width banks exercise both masked ports over all sixteen positions. The forced mask makes the ignored-clear rule on bank 0 observable both in register reads and on pin_oe.

// File: rtl/mbgpio_pkg.sv
package mbgpio_pkg;
  localparam int unsigned NUM_BANKS  = 4;
  localparam int unsigned HALF_W     = 16;
  localparam int unsigned ADDR_W     = 10;
  localparam int unsigned OFS_LO     = 'h000;
  localparam int unsigned OFS_HI     = 'h004;
  localparam int unsigned STEP_DATA  = 8;
  localparam int unsigned OFS_LVL    = 'h060;
  localparam int unsigned STEP_LVL   = 4;
  localparam int unsigned OFS_DIR    = 'h204;
  localparam int unsigned OFS_OE     = 'h208;
  localparam int unsigned STEP_CFG   = 'h40;
endpackage

// File: rtl/mbgpio_sync.sv
module mbgpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

  // cycles since reset, used to keep the latency check inside history
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  p_two_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/mbgpio_bank.sv
module mbgpio_bank #(
  parameter int unsigned W         = 32,
  parameter logic [31:0] FORCE_OUT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic         wr_dir,
  input  logic         wr_oe,
  input  logic [31:0]  wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [31:0]  rd_dir,
  output logic [31:0]  rd_oe,
  output logic [31:0]  rd_lvl
);
  import mbgpio_pkg::*;

  localparam int unsigned LO_W = (W < HALF_W) ? W : HALF_W;
  localparam int unsigned HI_W = (W > HALF_W) ? W - HALF_W : 0;
  localparam logic [W-1:0] FORCED = FORCE_OUT[W-1:0];

  logic [W-1:0] dout, dir, oe, drive, lvl_src, lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else begin
      for (int i = 0; i < LO_W; i++)
        if (wr_lo && !wdata[HALF_W+i]) dout[i] <= wdata[i];
      for (int i = 0; i < HI_W; i++)
        if (wr_hi && !wdata[HALF_W+i]) dout[HALF_W+i] <= wdata[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= FORCED;
      oe  <= '0;
    end else begin
      if (wr_dir) dir <= wdata[W-1:0] | FORCED;
      if (wr_oe)  oe  <= wdata[W-1:0];
    end
  end

  assign drive   = dir & oe;
  assign pin_out = dout;
  assign pin_oe  = drive;
  assign lvl_src = (drive & dout) | (~drive & pin_in);

  mbgpio_sync #(.W(W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (lvl_src),
    .q    (lvl)
  );

  always_comb begin
    rd_dir = '0;
    rd_oe  = '0;
    rd_lvl = '0;
    rd_dir[W-1:0] = dir;
    rd_oe[W-1:0]  = oe;
    rd_lvl[W-1:0] = lvl;
  end

  p_lo_apply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (((dout[LO_W-1:0] ^ $past(wdata[LO_W-1:0]))
               & ~$past(wdata[HALF_W +: LO_W])) == '0));

  p_lo_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (((dout[LO_W-1:0] ^ $past(dout[LO_W-1:0]))
               & $past(wdata[HALF_W +: LO_W])) == '0));

  generate
    if (HI_W > 0) begin : g_hi_chk
      p_hi_apply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (((dout[W-1:HALF_W] ^ $past(wdata[HI_W-1:0]))
                   & ~$past(wdata[HALF_W +: HI_W])) == '0));
      p_hi_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (((dout[W-1:HALF_W] ^ $past(dout[W-1:HALF_W]))
                   & $past(wdata[HALF_W +: HI_W])) == '0));
    end
  endgenerate

  p_dir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir));

  p_forced_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (dir == ($past(wdata[W-1:0]) | FORCED)));
endmodule

// File: rtl/mbgpio_top.sv
module mbgpio_top #(
  parameter int unsigned W0        = 32,
  parameter int unsigned W1        = 22,
  parameter int unsigned W2        = 32,
  parameter int unsigned W3        = 32,
  parameter logic [31:0] FORCE0    = 32'h0000_0180,
  parameter int unsigned AW        = mbgpio_pkg::ADDR_W,
  parameter int unsigned NPIN      = W0 + W1 + W2 + W3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            bus_rvalid,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);
  import mbgpio_pkg::*;

  localparam int unsigned BW [NUM_BANKS] = '{W0, W1, W2, W3};

  function automatic int unsigned pin_base(int unsigned b);
    int unsigned s = 0;
    for (int unsigned k = 0; k < b; k++) s += BW[k];
    return s;
  endfunction

  logic [31:0] bank_dir [NUM_BANKS];
  logic [31:0] bank_oe  [NUM_BANKS];
  logic [31:0] bank_lvl [NUM_BANKS];

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int unsigned BASE = pin_base(b);
      localparam logic [31:0] FM   = (b == 0) ? FORCE0 : 32'h0;
      logic wr_lo, wr_hi, wr_dir, wr_oe;

      assign wr_lo  = bus_wr && (bus_addr == AW'(OFS_LO  + STEP_DATA * b));
      assign wr_hi  = bus_wr && (bus_addr == AW'(OFS_HI  + STEP_DATA * b));
      assign wr_dir = bus_wr && (bus_addr == AW'(OFS_DIR + STEP_CFG  * b));
      assign wr_oe  = bus_wr && (bus_addr == AW'(OFS_OE  + STEP_CFG  * b));

      mbgpio_bank #(.W(BW[b]), .FORCE_OUT(FM)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .wr_dir (wr_dir),
        .wr_oe  (wr_oe),
        .wdata  (bus_wdata),
        .pin_in (pin_in[BASE +: BW[b]]),
        .pin_out(pin_out[BASE +: BW[b]]),
        .pin_oe (pin_oe[BASE +: BW[b]]),
        .rd_dir (bank_dir[b]),
        .rd_oe  (bank_oe[b]),
        .rd_lvl (bank_lvl[b])
      );
    end
  endgenerate

  logic [31:0] rd_mux;
  logic        rd_hit;

  always_comb begin
    rd_mux = '0;
    rd_hit = 1'b0;
    for (int unsigned b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == AW'(OFS_LVL + STEP_LVL * b)) begin
        rd_mux = bank_lvl[b];
        rd_hit = 1'b1;
      end
      if (bus_addr == AW'(OFS_DIR + STEP_CFG * b)) begin
        rd_mux = bank_dir[b];
        rd_hit = 1'b1;
      end
      if (bus_addr == AW'(OFS_OE + STEP_CFG * b)) begin
        rd_mux = bank_oe[b];
        rd_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_mux : '0;
    end
  end

  p_rvalid_after_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_rvalid_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  p_miss_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !rd_hit) |=> (bus_rdata == 32'h0));
endmodule

// File: tb/mbgpio_top_tb.sv
module mbgpio_top_tb;
  localparam int NPIN = 118;
  localparam int B1 = 32, B2 = 54, B3 = 86;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            bus_rvalid;
  logic [NPIN-1:0] pin_in = '0;
  logic [NPIN-1:0] pin_out, pin_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mbgpio_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R12 rvalid", {31'b0, bus_rvalid}, 32'h1);
    d = bus_rdata;
    @(negedge clk);
    chk("R12 rvalid drop", {31'b0, bus_rvalid}, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    chk("R1 pin_oe low", pin_oe[31:0] | pin_oe[117:86], 32'h0);
    chk("R1 pin_out low", pin_out[63:32], 32'h0);
    bus_read(10'h204, r); chk("R1 bank0 dir", r, 32'h0000_0180);
    bus_read(10'h244, r); chk("R1 bank1 dir", r, 32'h0);
    bus_read(10'h248, r); chk("R1 bank1 oe", r, 32'h0);
  endtask

  task automatic t_low_half();
    bus_write(10'h010, {16'h00F0, 16'hA5A5});
    chk("R2 bank2 low write", {16'h0, pin_out[B2 +: 16]}, 32'h0000_A505);
    bus_write(10'h010, {16'hFF00, 16'h00FF});
    chk("R4 bank2 protected bits", {16'h0, pin_out[B2 +: 16]}, 32'h0000_A5FF);
    chk("R3 bank2 high untouched", {16'h0, pin_out[B2+16 +: 16]}, 32'h0);
  endtask

  task automatic t_high_half();
    bus_write(10'h00C, {16'h0000, 16'hFFFF});
    chk("R3 bank1 high write", {26'h0, pin_out[B1+16 +: 6]}, 32'h3F);
    chk("R3 bank1 low untouched", {16'h0, pin_out[B1 +: 16]}, 32'h0);
    bus_write(10'h00C, {16'hFFFE, 16'h0000});
    chk("R4 bank1 only bit16 cleared", {26'h0, pin_out[B1+16 +: 6]}, 32'h3E);
  endtask

  task automatic t_unimpl();
    logic [31:0] r;
    bus_write(10'h244, 32'hFFFF_FFFF);
    bus_read(10'h244, r); chk("R10 bank1 dir width", r, 32'h003F_FFFF);
    bus_write(10'h244, 32'h0);
  endtask

  task automatic t_dir_oe();
    logic [31:0] r;
    bus_write(10'h2C4, 32'h0000_FFFF);
    bus_write(10'h2C8, 32'h00FF_00FF);
    bus_read(10'h2C4, r); chk("R5 bank3 dir", r, 32'h0000_FFFF);
    bus_read(10'h2C8, r); chk("R6 bank3 oe", r, 32'h00FF_00FF);
    chk("R6 bank3 pin_oe", pin_oe[B3 +: 32], 32'h0000_00FF);
  endtask

  task automatic t_forced();
    logic [31:0] r;
    bus_write(10'h204, 32'h0);
    bus_read(10'h204, r); chk("R7 bank0 forced dir", r, 32'h0000_0180);
    bus_write(10'h208, 32'hFFFF_FFFF);
    chk("R7 bank0 pin_oe", pin_oe[31:0], 32'h0000_0180);
  endtask

  task automatic t_input_sync();
    logic [31:0] r;
    @(negedge clk);
    pin_in[B3 +: 32] = 32'h1234_5678;
    @(posedge clk); @(posedge clk);
    bus_read(10'h06C, r);
    chk("R8 bank3 synced inputs", r, 32'h1234_5600);
  endtask

  task automatic t_readback();
    logic [31:0] r;
    bus_write(10'h018, {16'hFF00, 16'h00AB});
    @(posedge clk); @(posedge clk);
    bus_read(10'h06C, r);
    chk("R9 bank3 driven readback", r, 32'h1234_56AB);
  endtask

  task automatic t_unmapped();
    logic [31:0] r;
    logic [NPIN-1:0] so, se;
    bus_read(10'h000, r); chk("R11 write-only read", r, 32'h0);
    bus_read(10'h3FC, r); chk("R11 unmapped read", r, 32'h0);
    so = pin_out; se = pin_oe;
    bus_write(10'h06C, 32'hFFFF_FFFF);
    bus_write(10'h300, 32'h0000_0000);
    bus_write(10'h0FC, 32'h0000_FFFF);
    chk("R11 pin_out unchanged", 32'(so != pin_out), 32'h0);
    chk("R11 pin_oe unchanged", 32'(se != pin_oe), 32'h0);
    bus_read(10'h2C4, r); chk("R11 bank3 dir unchanged", r, 32'h0000_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_low_half();
    t_high_half();
    t_unimpl();
    t_dir_oe();
    t_forced();
    t_input_sync();
    t_readback();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule